// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a 32-bit register-transfer processor core. Each cycle it takes a first operand, a second operand that an upstream shifter has already shifted or that decode has taken from an immediate, a 4-bit operation code and a set-flags request. It returns the result and says whether that result is to be written back. It also holds the four condition flags: negative, zero, carry and overflow.

The sixteen operations are logical, arithmetic, move and compare/test operations. The arithmetic group includes forward and reverse subtraction, with and without the incoming carry. The four compare/test operations only change the flags and never request a result write. The flag register advances on a clock edge only when the step strobe is high. Ordinary operations update the flags only when the set-flags request is high. Compare/test operations always update them.

Top module: `dpu_alu`

## Requirements
- R1: While reset is held, and in the first cycle after it, the flags port reads 0000. The flags port packs N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.
- R2: Logical and move codes are AND=0 (a&b), EOR=1 (a^b), ORR=12 (a|b), BIC=14 (a&~b), MOV=13 (b) and MVN=15 (~b). The result port shows the value combinationally.
- R3: ADD=4 gives a+b, SUB=2 gives a-b and RSB=3 gives b-a, each modulo 2^32.
- R4: ADC=5 gives a+b+C. SBC=6 gives a-b-(1-C). RSC=7 gives b-a-(1-C). C is the flag held in the register.
- R5: resultWe equals stepEn for every code except TST=8, TEQ=9, CMP=10 and CMN=11. For those four codes resultWe is always 0.
- R6: The flags change only at a rising clock edge where stepEn=1 and either setFlags=1 or the code is in the range 8 to 11. In every other cycle the flags hold their value.
- R7: On an update from an arithmetic code (2 to 7, 10, 11), C is the adder carry-out. A subtraction with no borrow gives C=1. V is set on two's-complement signed overflow.
- R8: On an update from a logical or move code (0, 1, 8, 9, 12 to 15), C takes the shiftCarry input and V keeps its previous value.
- R9: On every update, N is bit 31 of the operation value and Z is 1 exactly when that value is all zeros.
- R10: CMP updates the flags from a-b, CMN from a+b, TEQ from a^b and TST from a&b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, already shifted or immediate |
| opCode | input | 4 | Operation code |
| setFlags | input | 1 | Request to update flags on ordinary operations |
| shiftCarry | input | 1 | Carry-out from the shifter |
| stepEn | input | 1 | Clock-enable strobe for this operation |
| result | output | 32 | Operation value |
| resultWe | output | 1 | Result write enable |
| flags | output | 4 | Current flags {N,Z,C,V} |

## Verification
The bench builds the block with its default WIDTH of 32. This puts the carry and overflow boundaries at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF within reach of both the directed cases and the weighted random operands. At that width the bench reference model can do its arithmetic in 64-bit integers, which keeps it independent of the adder structure in the design. Random stepEn and setFlags values exercise every combination of flag hold and update across all sixteen codes.

// File: rtl/dpu_alu_pkg.sv
package dpu_alu_pkg;
  typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } cinSel_e;
  typedef enum logic [2:0] { LG_AND, LG_XOR, LG_OR, LG_BIC, LG_PASSB, LG_NOTB } logicSel_e;

  typedef struct packed {
    logic      isArith;
    logic      invA;
    logic      invB;
    cinSel_e   cinSel;
    logicSel_e logicSel;
    logic      updFlags;
  } aluCtl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } aluFlags_t;
endpackage

// File: rtl/dpu_alu_ctrl.sv
module dpu_alu_ctrl
  import dpu_alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       setFlags,
  input  logic       stepEn,
  output aluCtl_t    ctl,
  output logic       resultWe
);
  logic isCompare;

  assign isCompare = (opCode[3:2] == 2'b10);

  always_comb begin
    ctl          = '0;
    ctl.cinSel   = CIN_ZERO;
    ctl.logicSel = LG_AND;
    unique case (opCode)
      4'd0:  ctl.logicSel = LG_AND;
      4'd1:  ctl.logicSel = LG_XOR;
      4'd2:  begin ctl.isArith = 1'b1; ctl.invB = 1'b1; ctl.cinSel = CIN_ONE;  end
      4'd3:  begin ctl.isArith = 1'b1; ctl.invA = 1'b1; ctl.cinSel = CIN_ONE;  end
      4'd4:  begin ctl.isArith = 1'b1; end
      4'd5:  begin ctl.isArith = 1'b1; ctl.cinSel = CIN_FLAG; end
      4'd6:  begin ctl.isArith = 1'b1; ctl.invB = 1'b1; ctl.cinSel = CIN_FLAG; end
      4'd7:  begin ctl.isArith = 1'b1; ctl.invA = 1'b1; ctl.cinSel = CIN_FLAG; end
      4'd8:  ctl.logicSel = LG_AND;
      4'd9:  ctl.logicSel = LG_XOR;
      4'd10: begin ctl.isArith = 1'b1; ctl.invB = 1'b1; ctl.cinSel = CIN_ONE;  end
      4'd11: begin ctl.isArith = 1'b1; end
      4'd12: ctl.logicSel = LG_OR;
      4'd13: ctl.logicSel = LG_PASSB;
      4'd14: ctl.logicSel = LG_BIC;
      default: ctl.logicSel = LG_NOTB;
    endcase
    ctl.updFlags = stepEn && (setFlags || isCompare);
  end

  assign resultWe = stepEn && !isCompare;
endmodule

// File: rtl/dpu_alu_path.sv
module dpu_alu_path
  import dpu_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             shiftCarry,
  input  aluCtl_t          ctl,
  output logic [WIDTH-1:0] result,
  output aluFlags_t        flagQ
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addX, addY, logicRes;
  logic [WIDTH:0]   sumFull;
  logic             carryIn, overflow;
  aluFlags_t        flagD;

  always_comb begin
    addX = ctl.invA ? ~opA : opA;
    addY = ctl.invB ? ~opB : opB;
    unique case (ctl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagQ.c;
      default:  carryIn = 1'b0;
    endcase
    sumFull  = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, carryIn};
    overflow = (addX[MSB] == addY[MSB]) && (sumFull[MSB] != addX[MSB]);
  end

  always_comb begin
    unique case (ctl.logicSel)
      LG_XOR:   logicRes = opA ^ opB;
      LG_OR:    logicRes = opA | opB;
      LG_BIC:   logicRes = opA & ~opB;
      LG_PASSB: logicRes = opB;
      LG_NOTB:  logicRes = ~opB;
      default:  logicRes = opA & opB;
    endcase
  end

  assign result = ctl.isArith ? sumFull[MSB:0] : logicRes;

  always_comb begin
    flagD.n = result[MSB];
    flagD.z = (result == '0);
    flagD.c = ctl.isArith ? sumFull[WIDTH] : shiftCarry;
    flagD.v = ctl.isArith ? overflow : flagQ.v;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= '0;
    else if (ctl.updFlags) flagQ <= flagD;
  end
endmodule

// File: rtl/dpu_alu.sv
module dpu_alu
  import dpu_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opCode,
  input  logic             setFlags,
  input  logic             shiftCarry,
  input  logic             stepEn,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic [3:0]       flags
);
  aluCtl_t   ctl;
  aluFlags_t flagQ;

  dpu_alu_ctrl u_ctrl (
    .opCode   (opCode),
    .setFlags (setFlags),
    .stepEn   (stepEn),
    .ctl      (ctl),
    .resultWe (resultWe)
  );

  dpu_alu_path #(.WIDTH(WIDTH)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .ctl        (ctl),
    .result     (result),
    .flagQ      (flagQ)
  );

  assign flags = flagQ;
endmodule

// File: rtl/dpu_alu_chk.sv
module dpu_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opCode,
  input logic             setFlags,
  input logic             shiftCarry,
  input logic             stepEn,
  input logic [WIDTH-1:0] result,
  input logic             resultWe,
  input logic [3:0]       flags
);
  logic cmpCode, logicCode;
  assign cmpCode   = (opCode >= 4'd8) && (opCode <= 4'd11);
  assign logicCode = (opCode <= 4'd1) || (opCode == 4'd8) || (opCode == 4'd9) || (opCode >= 4'd12);

  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> flags == 4'b0000);  // R1

  AST_MOVE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 4'd13 |-> result == opB);  // R2

  AST_NO_WRITE_CMP: assert property (@(posedge clk) disable iff (!rstN)
    cmpCode |-> !resultWe);  // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stepEn && (setFlags || cmpCode)) |=> $stable(flags));  // R6

  AST_LOGIC_CV: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && setFlags && logicCode) |=>
      (flags[1] == $past(shiftCarry)) && (flags[0] == $past(flags[0])));  // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && setFlags) |=> flags[2] == ($past(result) == '0));  // R9

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && setFlags) |=> flags[3] == $past(result[WIDTH-1]));  // R9
endmodule

bind dpu_alu dpu_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
  .setFlags(setFlags), .shiftCarry(shiftCarry), .stepEn(stepEn),
  .result(result), .resultWe(resultWe), .flags(flags)
);

// File: tb/sim_dpu_alu.sv
`timescale 1ns/1ps
module sim_dpu_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  opCode = '0;
  logic        setFlags = 1'b0, shiftCarry = 1'b0, stepEn = 1'b0;
  logic [31:0] result;
  logic        resultWe;
  logic [3:0]  flags;

  int checks = 0;
  int fails = 0;
  logic [3:0] modelFlags = 4'b0000;

  always #2 clk = ~clk;

  dpu_alu u0 (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .setFlags(setFlags), .shiftCarry(shiftCarry), .stepEn(stepEn),
    .result(result), .resultWe(resultWe), .flags(flags)
  );

  function automatic string reqOf(input logic [3:0] op);
    if (op == 4'd2 || op == 4'd3 || op == 4'd4) return "R3/R7";
    if (op >= 4'd5 && op <= 4'd7)               return "R4/R7";
    if (op >= 4'd8 && op <= 4'd11)              return "R10";
    return "R2/R8";
  endfunction

  // Reference: returns {flagsIfUpdated, value}
  function automatic logic [35:0] refOp(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [3:0] fl,
                                        input logic sc);
    longint ua, ub, full, sa, sb, sfull;
    logic [31:0] val;
    logic c, v, arith;
    longint cBit;
    cBit = fl[1] ? 64'sd1 : 64'sd0;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    arith = 1'b1;
    full = 0; sfull = 0; val = '0;
    case (op)
      4'd4, 4'd11: begin full = ua + ub;            sfull = sa + sb; end
      4'd5:        begin full = ua + ub + cBit;     sfull = sa + sb + cBit; end
      4'd2, 4'd10: begin full = ua - ub;            sfull = sa - sb; end
      4'd6:        begin full = ua - ub - (1 - cBit); sfull = sa - sb - (1 - cBit); end
      4'd3:        begin full = ub - ua;            sfull = sb - sa; end
      4'd7:        begin full = ub - ua - (1 - cBit); sfull = sb - sa - (1 - cBit); end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      val = full[31:0];
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) c = (full > 64'sd4294967295);
      else c = (full >= 0);
      v = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8: val = a & b;
        4'd1, 4'd9: val = a ^ b;
        4'd12:      val = a | b;
        4'd13:      val = b;
        4'd14:      val = a & ~b;
        default:    val = ~b;
      endcase
      c = sc;
      v = fl[0];
    end
    return {val[31], (val == 32'd0), c, v, val};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input logic sc, input logic en);
    logic [35:0] exp;
    logic        expWe, upd;
    @(negedge clk);
    opCode = op; opA = a; opB = b; setFlags = sf; shiftCarry = sc; stepEn = en;
    #1;
    exp   = refOp(op, a, b, modelFlags, sc);
    expWe = en && !(op >= 4'd8 && op <= 4'd11);
    check(result == exp[31:0], reqOf(op), "result", result, exp[31:0]);
    check(resultWe == expWe, "R5", "resultWe", {31'b0, resultWe}, {31'b0, expWe});
    upd = en && (sf || (op >= 4'd8 && op <= 4'd11));
    @(posedge clk);
    #1;
    if (upd) modelFlags = exp[35:32];
    check(flags == modelFlags, upd ? {"R6/R9/", reqOf(op)} : "R6 hold", "flags",
          {28'b0, flags}, {28'b0, modelFlags});
  endtask

  function automatic logic [31:0] pickOperand();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    repeat (3) @(posedge clk);
    #1;
    check(flags == 4'b0000, "R1", "flags in reset", {28'b0, flags}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(flags == 4'b0000, "R1", "flags after reset", {28'b0, flags}, 32'h0);

    // Directed corner cases
    runOp(4'd4, 32'h7FFF_FFFF, 32'h1, 1, 0, 1);          // R7 signed overflow, N=1 V=1
    runOp(4'd4, 32'hFFFF_FFFF, 32'h1, 1, 0, 1);          // R7 carry out, Z=1
    runOp(4'd2, 32'h5, 32'h5, 1, 0, 1);                  // R7 no borrow C=1
    runOp(4'd2, 32'h0, 32'h1, 1, 0, 1);                  // R7 borrow C=0
    runOp(4'd5, 32'h10, 32'h20, 1, 0, 1);                // R4 ADC with C=0
    runOp(4'd6, 32'h10, 32'h3, 1, 0, 1);                 // R4 SBC
    runOp(4'd7, 32'h3, 32'h10, 1, 1, 1);                 // R4 RSC
    runOp(4'd3, 32'h1, 32'h0, 1, 0, 1);                  // R3 RSB
    runOp(4'd14, 32'hF0F0_FFFF, 32'h0000_FFFF, 1, 1, 1); // R2 BIC, R8 C from shifter
    runOp(4'd15, 32'h0, 32'h0, 0, 0, 1);                 // R2 MVN, R6 no update
    runOp(4'd10, 32'h8000_0000, 32'h1, 0, 0, 1);         // R10 CMP forces update
    runOp(4'd11, 32'h1, 32'hFFFF_FFFF, 0, 1, 1);         // R10 CMN
    runOp(4'd9, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 0, 0, 1);  // R10 TEQ equal -> Z
    runOp(4'd8, 32'h0F00_0000, 32'hF000_0000, 0, 1, 0);  // R6 stepEn low holds
    runOp(4'd13, 32'h0, 32'h8000_0000, 1, 0, 1);         // R2 MOV, R9 N

    // Constrained random
    for (int i = 0; i < 1500; i++) begin
      runOp(4'($urandom_range(0, 15)), pickOperand(), pickOperand(),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 9) != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule